// File: doc/BRIEF.md
# Per-Processor Highest-Pending Interrupt Selector

This block sits between an interrupt distributor's per-interrupt state and the processors it serves. For every processor it looks through all interrupt IDs. It keeps those that are both enabled and pending for that processor and picks the one with the numerically smallest priority value. It then decides two things. The first is whether the winner's ID is reported as the highest-pending interrupt, which depends on the processor's priority mask. The second is whether the processor's interrupt line is raised, which depends on the priority the processor is already running at.

The selection is done as an iterative scan, `LANES` IDs per cycle, for all processors in parallel. Whatever logic owns the enable and pending state pulses `start_scan` whenever any of the inputs change. A pulse that arrives while a scan is running restarts the scan. The outputs hold their previous values until a scan completes. On completion they update and `scan_done` pulses for one cycle.

Top module: `hp_select`

## Requirements
- R1: An interrupt is a candidate for a processor only if both its enable bit and its pending bit for that processor are 1. Bit `c*NUM_IRQ+i` of each vector belongs to processor c and ID i.
- R2: Among candidates, the one with the numerically lowest 8-bit priority value wins.
- R3: When candidates tie on priority, the lowest ID wins.
- R4: With no candidate, the reported ID is 1023 and the line is low.
- R5: The winner's ID is reported only if its priority is less than or equal to the processor's mask (8 bits at `prio_mask[c*8 +: 8]`). Otherwise the ID is 1023 and the line is low.
- R6: The line is high only if the reported winner's priority is strictly below the processor's running priority (9 bits at `run_prio[c*9 +: 9]`; 0x100 means idle). When the two are equal, the ID is still shown and the line stays low.
- R7: If `dist_enable` is 0, or the processor's bit of `cpu_if_enable` is 0, that processor reports 1023 and its line is low.
- R8: IDs below NUM_BANKED take their priority from the processor's own bank, at byte `c*NUM_BANKED+i` of `prio_banked`. IDs at or above NUM_BANKED share one byte across all processors, at byte `i-NUM_BANKED` of `prio_shared`.
- R9: The ID and line outputs, and a one-cycle `scan_done` pulse, appear on the `NUM_IRQ/LANES`-th rising edge after the edge that samples `start_scan`. Until then the previous outputs are held. A new `start_scan` during a scan restarts it from ID 0.
- R10: After reset every ID output is 1023, every line is low and `scan_done` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_scan | input | 1 | Begin (or restart) a scan |
| en_bits | input | NUM_CPU*NUM_IRQ | Enable bit per processor and ID |
| pend_bits | input | NUM_CPU*NUM_IRQ | Pending bit per processor and ID |
| prio_banked | input | NUM_CPU*NUM_BANKED*8 | Per-processor priorities for low IDs |
| prio_shared | input | (NUM_IRQ-NUM_BANKED)*8 | Shared priorities for high IDs |
| dist_enable | input | 1 | Global distributor enable |
| cpu_if_enable | input | NUM_CPU | Per-processor interface enable |
| prio_mask | input | NUM_CPU*8 | Per-processor priority mask |
| run_prio | input | NUM_CPU*9 | Per-processor running priority |
| hp_id | output | NUM_CPU*10 | Highest-pending ID per processor (1023 = none) |
| irq_line | output | NUM_CPU | Registered interrupt line per processor |
| scan_done | output | 1 | One-cycle pulse when outputs update |

## Verification
The bench targets the two thresholds of the double gate. A winner exactly at the mask must be shown, and a winner exactly at the running priority must be shown without raising the line. A design that used `<` for the mask, or `<=` against the running priority, fails these checks. Priority ties are placed both inside one scan chunk and across chunks. This catches a design that lets a later chunk overwrite an equal earlier winner. It also catches a design that uses `<=` within a chunk. Banked and shared priorities are set so that the two processors choose different winners, which exposes a design that reads the wrong bank. Timing checks confirm that the outputs hold until exactly the final scan edge, and that a mid-scan restart suppresses the first completion and reports the newer inputs.

// File: rtl/hps_pkg.sv
// Shared constants for the highest-pending selector.
// Assumes 8-bit priorities and 10-bit interrupt IDs with 1023 reserved as "none".
package hps_pkg;
    localparam int PRIO_W = 8;
    localparam int ID_W   = 10;
    localparam logic [ID_W-1:0]   NO_ID     = 10'd1023;
    localparam logic [PRIO_W:0]   IDLE_PRIO = 9'h100;
endpackage

// File: rtl/hps_scan_ctrl.sv
// Scan sequencer: walks a step index over NUM_IRQ/LANES chunks after start,
// flags the final step and emits a one-cycle done pulse.
// Assumes STEPS >= 2; a start while busy restarts from step 0.
module hps_scan_ctrl #(
    parameter int STEPS = 16,
    parameter int LANES = 4,
    parameter int IW    = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output logic          busy,
    output logic          fin,
    output logic [IW-1:0] base_id,
    output logic          done
);
    localparam int SW = (STEPS > 1) ? $clog2(STEPS) : 1;

    logic [SW-1:0] step_q;

    // Final chunk is being merged this cycle (and no restart pending).
    assign fin     = busy && !start && (step_q == SW'(STEPS - 1));
    assign base_id = IW'(int'(step_q) * LANES);

    // Step counter, busy flag and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            step_q <= '0;
            done   <= 1'b0;
        end else begin
            done <= fin;
            if (start) begin
                busy   <= 1'b1;
                step_q <= '0;
            end else if (fin) begin
                busy   <= 1'b0;
                step_q <= '0;
            end else if (busy) begin
                step_q <= step_q + 1'b1;
            end
        end
    end

    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r9_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);
endmodule

// File: rtl/hps_chunk_pick.sv
// Combinational pick over LANES consecutive IDs starting at base_id:
// lowest priority value among enabled and pending IDs, lowest ID on a tie.
// Assumes NUM_IRQ and NUM_BANKED are powers of two and NUM_IRQ > NUM_BANKED.
module hps_chunk_pick
    import hps_pkg::*;
#(
    parameter int NUM_IRQ    = 64,
    parameter int NUM_BANKED = 32,
    parameter int LANES      = 4,
    parameter int IW         = 6
) (
    input  logic [IW-1:0]                          base_id,
    input  logic [NUM_IRQ-1:0]                     en_v,
    input  logic [NUM_IRQ-1:0]                     pend_v,
    input  logic [NUM_BANKED*PRIO_W-1:0]           prio_own,
    input  logic [(NUM_IRQ-NUM_BANKED)*PRIO_W-1:0] prio_common,
    output logic [PRIO_W:0]                        pick_prio,
    output logic [ID_W-1:0]                        pick_id
);
    localparam int OW = $clog2(NUM_BANKED);
    localparam int CW = $clog2(NUM_IRQ - NUM_BANKED);

    // Ascending scan with strict compare so the earliest lane wins ties.
    always_comb begin
        pick_prio = IDLE_PRIO;
        pick_id   = NO_ID;
        for (int k = 0; k < LANES; k++) begin
            logic [IW-1:0]   idx;
            logic [IW-1:0]   cidx;
            logic [PRIO_W:0] p;
            idx  = base_id + IW'(k);
            cidx = idx - IW'(NUM_BANKED);
            if (idx < IW'(NUM_BANKED))
                p = {1'b0, prio_own[idx[OW-1:0]*PRIO_W +: PRIO_W]};
            else
                p = {1'b0, prio_common[cidx[CW-1:0]*PRIO_W +: PRIO_W]};
            if (en_v[idx] && pend_v[idx] && (p < pick_prio)) begin
                pick_prio = p;
                pick_id   = ID_W'(idx);
            end
        end
    end
endmodule

// File: rtl/hps_cpu_lane.sv
// One processor's scan datapath: running best over chunks, then the mask
// and running-priority gates into registered ID and line outputs.
// Assumes the sequencer's start/busy/fin timing; inputs stable during a scan.
module hps_cpu_lane
    import hps_pkg::*;
#(
    parameter int NUM_IRQ    = 64,
    parameter int NUM_BANKED = 32,
    parameter int LANES      = 4,
    parameter int IW         = 6
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   start,
    input  logic                                   busy,
    input  logic                                   fin,
    input  logic [IW-1:0]                          base_id,
    input  logic [NUM_IRQ-1:0]                     en_v,
    input  logic [NUM_IRQ-1:0]                     pend_v,
    input  logic [NUM_BANKED*PRIO_W-1:0]           prio_own,
    input  logic [(NUM_IRQ-NUM_BANKED)*PRIO_W-1:0] prio_common,
    input  logic                                   dist_en,
    input  logic                                   if_en,
    input  logic [PRIO_W-1:0]                      mask,
    input  logic [PRIO_W:0]                        run_prio,
    output logic [ID_W-1:0]                        hp_id_q,
    output logic                                   irq_q
);
    logic [PRIO_W:0]  pick_prio, best_prio, merged_prio;
    logic [ID_W-1:0]  pick_id, best_id, merged_id;

    hps_chunk_pick #(
        .NUM_IRQ(NUM_IRQ), .NUM_BANKED(NUM_BANKED), .LANES(LANES), .IW(IW)
    ) u_pick (
        .base_id(base_id), .en_v(en_v), .pend_v(pend_v),
        .prio_own(prio_own), .prio_common(prio_common),
        .pick_prio(pick_prio), .pick_id(pick_id)
    );

    // Later chunks hold higher IDs, so they replace the best only when strictly better.
    always_comb begin
        if (pick_prio < best_prio) begin
            merged_prio = pick_prio;
            merged_id   = pick_id;
        end else begin
            merged_prio = best_prio;
            merged_id   = best_id;
        end
    end

    // Running best across the chunks of one scan.
    always_ff @(posedge clk) begin
        if (!rst_n || start) begin
            best_prio <= IDLE_PRIO;
            best_id   <= NO_ID;
        end else if (busy) begin
            best_prio <= merged_prio;
            best_id   <= merged_id;
        end
    end

    // Gate the final winner into the registered outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hp_id_q <= NO_ID;
            irq_q   <= 1'b0;
        end else if (fin) begin
            if (!(dist_en && if_en)) begin
                hp_id_q <= NO_ID;
                irq_q   <= 1'b0;
            end else if (merged_prio <= {1'b0, mask}) begin
                hp_id_q <= merged_id;
                irq_q   <= (merged_prio < run_prio);
            end else begin
                hp_id_q <= NO_ID;
                irq_q   <= 1'b0;
            end
        end
    end

    a_r7_disabled_low: assert property (@(posedge clk) disable iff (!rst_n)
        fin && !(dist_en && if_en) |=> (hp_id_q == NO_ID) && !irq_q);
    a_r4_line_has_id: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> (hp_id_q != NO_ID));
    a_r9_hold_outputs: assert property (@(posedge clk) disable iff (!rst_n)
        !fin |=> $stable(hp_id_q) && $stable(irq_q));
    a_r2_best_never_worse: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !start |=> best_prio <= $past(best_prio));
endmodule

// File: rtl/hp_select.sv
// Top: one shared scan sequencer and one datapath lane per processor.
// Assumes NUM_IRQ is a multiple of LANES, both powers of two, NUM_IRQ <= 1024.
module hp_select
    import hps_pkg::*;
#(
    parameter int NUM_IRQ    = 64,
    parameter int NUM_CPU    = 2,
    parameter int NUM_BANKED = 32,
    parameter int LANES      = 4
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   start_scan,
    input  logic [NUM_CPU*NUM_IRQ-1:0]             en_bits,
    input  logic [NUM_CPU*NUM_IRQ-1:0]             pend_bits,
    input  logic [NUM_CPU*NUM_BANKED*8-1:0]        prio_banked,
    input  logic [(NUM_IRQ-NUM_BANKED)*8-1:0]      prio_shared,
    input  logic                                   dist_enable,
    input  logic [NUM_CPU-1:0]                     cpu_if_enable,
    input  logic [NUM_CPU*8-1:0]                   prio_mask,
    input  logic [NUM_CPU*9-1:0]                   run_prio,
    output logic [NUM_CPU*10-1:0]                  hp_id,
    output logic [NUM_CPU-1:0]                     irq_line,
    output logic                                   scan_done
);
    localparam int STEPS = NUM_IRQ / LANES;
    localparam int IW    = $clog2(NUM_IRQ);

    logic          busy, fin;
    logic [IW-1:0] base_id;

    hps_scan_ctrl #(.STEPS(STEPS), .LANES(LANES), .IW(IW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start_scan),
        .busy(busy), .fin(fin), .base_id(base_id), .done(scan_done)
    );

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
        hps_cpu_lane #(
            .NUM_IRQ(NUM_IRQ), .NUM_BANKED(NUM_BANKED), .LANES(LANES), .IW(IW)
        ) u_lane (
            .clk(clk), .rst_n(rst_n), .start(start_scan),
            .busy(busy), .fin(fin), .base_id(base_id),
            .en_v(en_bits[c*NUM_IRQ +: NUM_IRQ]),
            .pend_v(pend_bits[c*NUM_IRQ +: NUM_IRQ]),
            .prio_own(prio_banked[c*NUM_BANKED*8 +: NUM_BANKED*8]),
            .prio_common(prio_shared),
            .dist_en(dist_enable), .if_en(cpu_if_enable[c]),
            .mask(prio_mask[c*8 +: 8]), .run_prio(run_prio[c*9 +: 9]),
            .hp_id_q(hp_id[c*10 +: 10]), .irq_q(irq_line[c])
        );
    end
endmodule

// File: tb/hp_select_bench.sv
`timescale 1ns/1ps
module hp_select_bench;
    localparam int NI = 64, NC = 2, NB = 32, LN = 4, SH = NI - NB;
    localparam int STEPS = NI / LN;

    logic clk = 1'b0, rst_n = 1'b0, start_scan = 1'b0;
    logic [NC*NI-1:0] en_bits, pend_bits;
    logic [NC*NB*8-1:0] prio_banked;
    logic [SH*8-1:0] prio_shared;
    logic dist_enable;
    logic [NC-1:0] cpu_if_enable;
    logic [NC*8-1:0] prio_mask;
    logic [NC*9-1:0] run_prio;
    logic [NC*10-1:0] hp_id;
    logic [NC-1:0] irq_line;
    logic scan_done;

    // Bench-side state, packed onto the ports.
    logic       en [NC][NI];
    logic       pend [NC][NI];
    logic [7:0] pb [NC][NB];
    logic [7:0] ps [SH];
    logic [7:0] mk [NC];
    logic [8:0] rp [NC];
    logic       ife [NC];

    int checks = 0, errors = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    always_comb begin
        for (int c = 0; c < NC; c++) begin
            for (int i = 0; i < NI; i++) begin
                en_bits[c*NI+i]   = en[c][i];
                pend_bits[c*NI+i] = pend[c][i];
            end
            for (int i = 0; i < NB; i++) prio_banked[(c*NB+i)*8 +: 8] = pb[c][i];
            prio_mask[c*8 +: 8] = mk[c];
            run_prio[c*9 +: 9]  = rp[c];
            cpu_if_enable[c]    = ife[c];
        end
        for (int i = 0; i < SH; i++) prio_shared[i*8 +: 8] = ps[i];
    end

    hp_select #(.NUM_IRQ(NI), .NUM_CPU(NC), .NUM_BANKED(NB), .LANES(LN)) u_hp_select (
        .clk(clk), .rst_n(rst_n), .start_scan(start_scan),
        .en_bits(en_bits), .pend_bits(pend_bits),
        .prio_banked(prio_banked), .prio_shared(prio_shared),
        .dist_enable(dist_enable), .cpu_if_enable(cpu_if_enable),
        .prio_mask(prio_mask), .run_prio(run_prio),
        .hp_id(hp_id), .irq_line(irq_line), .scan_done(scan_done)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic check_cpu(input string req, input int c, input int eid, input int eirq);
        check(req, int'(hp_id[c*10 +: 10]), eid);
        check(req, int'(irq_line[c]), eirq);
    endtask

    // Reference from the requirements: candidate filter, min scan, double gate.
    task automatic model(input int c, output int eid, output int eirq);
        int bp = 256, bi = 1023, p;
        for (int i = 0; i < NI; i++) begin
            p = (i < NB) ? int'(pb[c][i]) : int'(ps[i-NB]);
            if (en[c][i] && pend[c][i] && p < bp) begin bp = p; bi = i; end
        end
        if (!dist_enable || !ife[c]) begin eid = 1023; eirq = 0; end
        else if (bp <= int'(mk[c])) begin eid = bi; eirq = (bp < int'(rp[c])) ? 1 : 0; end
        else begin eid = 1023; eirq = 0; end
    endtask

    task automatic clear_all();
        for (int c = 0; c < NC; c++) begin
            for (int i = 0; i < NI; i++) begin en[c][i] = 0; pend[c][i] = 0; end
            for (int i = 0; i < NB; i++) pb[c][i] = 8'hFF;
            mk[c] = 8'hFF; rp[c] = 9'h100; ife[c] = 1;
        end
        for (int i = 0; i < SH; i++) ps[i] = 8'hFF;
        dist_enable = 1;
    endtask

    task automatic set_irq(input int c, input int id, input int p);
        en[c][id] = 1; pend[c][id] = 1;
        if (id < NB) pb[c][id] = 8'(p); else ps[id-NB] = 8'(p);
    endtask

    task automatic do_scan();
        @(negedge clk) start_scan = 1;
        @(negedge clk) start_scan = 0;
        repeat (STEPS) @(negedge clk);
    endtask

    task automatic t_reset();
        check("R10 id0", int'(hp_id[9:0]), 1023);
        check("R10 id1", int'(hp_id[19:10]), 1023);
        check("R10 irq", int'(irq_line), 0);
        check("R10 done", int'(scan_done), 0);
    endtask

    task automatic t_empty();
        clear_all();
        for (int i = 0; i < NI; i++) en[0][i] = 1;
        do_scan();
        check_cpu("R4 none", 0, 1023, 0);
        check_cpu("R4 none", 1, 1023, 0);
    endtask

    task automatic t_candidate();
        clear_all();
        pend[0][20] = 1; pend[1][20] = 1; en[1][20] = 1; pb[1][20] = 8'h30;
        en[0][21] = 1;  pb[0][21] = 8'h10;   // enabled but not pending
        do_scan();
        check_cpu("R1 not enabled", 0, 1023, 0);
        check_cpu("R1 both set", 1, 20, 1);
    endtask

    task automatic t_lowest();
        clear_all();
        set_irq(0, 5, 8'h80); set_irq(0, 40, 8'h20); set_irq(0, 63, 8'h30);
        do_scan();
        check_cpu("R2 lowest value", 0, 40, 1);
    endtask

    task automatic t_tie();
        clear_all();
        set_irq(0, 10, 8'h40); set_irq(0, 50, 8'h40);   // across chunks
        set_irq(1, 33, 8'h60); set_irq(1, 34, 8'h60);   // same chunk
        ps[34-NB] = 8'h60;
        do_scan();
        check_cpu("R3 tie cross", 0, 10, 1);
        check_cpu("R3 tie chunk", 1, 33, 1);
    endtask

    task automatic t_mask();
        clear_all();
        set_irq(0, 12, 8'hF0); mk[0] = 8'hF0;
        set_irq(1, 12, 8'hF0); mk[1] = 8'hEF;
        do_scan();
        check_cpu("R5 equal mask shown", 0, 12, 1);
        check_cpu("R5 above mask hidden", 1, 1023, 0);
    endtask

    task automatic t_running();
        clear_all();
        set_irq(0, 8, 8'h40); rp[0] = 9'h040;
        set_irq(1, 8, 8'h40); rp[1] = 9'h041;
        do_scan();
        check_cpu("R6 equal running", 0, 8, 0);
        check_cpu("R6 below running", 1, 8, 1);
        rp[0] = 9'h100;
        do_scan();
        check_cpu("R6 idle running", 0, 8, 1);
    endtask

    task automatic t_enables();
        clear_all();
        set_irq(0, 45, 8'h10); set_irq(1, 45, 8'h10);
        ife[1] = 0;
        do_scan();
        check_cpu("R7 if on", 0, 45, 1);
        check_cpu("R7 if off", 1, 1023, 0);
        dist_enable = 0;
        do_scan();
        check_cpu("R7 dist off", 0, 1023, 0);
    endtask

    task automatic t_bank();
        clear_all();
        set_irq(0, 7, 8'h10); set_irq(1, 7, 8'hA0); pb[0][7] = 8'h10; pb[1][7] = 8'hA0;
        set_irq(0, 3, 8'h50); set_irq(1, 3, 8'h50);
        do_scan();
        check_cpu("R8 banked cpu0", 0, 7, 1);
        check_cpu("R8 banked cpu1", 1, 3, 1);
        set_irq(0, 45, 8'h05); set_irq(1, 45, 8'h05);
        do_scan();
        check_cpu("R8 shared cpu0", 0, 45, 1);
        check_cpu("R8 shared cpu1", 1, 45, 1);
    endtask

    task automatic t_timing();
        clear_all(); set_irq(0, 12, 8'h20);
        do_scan();
        check("R9 first", int'(hp_id[9:0]), 12);
        en[0][12] = 0; set_irq(0, 40, 8'h20);
        @(negedge clk) start_scan = 1;
        @(negedge clk) start_scan = 0;
        repeat (STEPS-1) @(negedge clk);
        check("R9 held", int'(hp_id[9:0]), 12);
        check("R9 no early done", int'(scan_done), 0);
        @(negedge clk);
        check("R9 update", int'(hp_id[9:0]), 40);
        check("R9 done", int'(scan_done), 1);
        @(negedge clk);
        check("R9 done pulse", int'(scan_done), 0);
        // restart mid-scan
        en[0][40] = 0; set_irq(0, 20, 8'h20);
        @(negedge clk) start_scan = 1;
        @(negedge clk) start_scan = 0;
        repeat (5) @(negedge clk);
        en[0][20] = 0; set_irq(0, 50, 8'h20);
        start_scan = 1;
        @(negedge clk) start_scan = 0;
        repeat (10) @(negedge clk);
        check("R9 restart no done", int'(scan_done), 0);
        check("R9 restart held", int'(hp_id[9:0]), 40);
        repeat (6) @(negedge clk);
        check("R9 restart done", int'(scan_done), 1);
        check("R9 restart value", int'(hp_id[9:0]), 50);
    endtask

    task automatic t_random();
        int eid, eirq;
        for (int n = 0; n < 20; n++) begin
            clear_all();
            for (int c = 0; c < NC; c++) begin
                for (int i = 0; i < NI; i++) begin
                    en[c][i] = ($urandom_range(0, 3) != 0);
                    pend[c][i] = ($urandom_range(0, 5) == 0);
                end
                for (int i = 0; i < NB; i++) pb[c][i] = 8'($urandom_range(0, 15) * 16);
                mk[c] = 8'($urandom_range(0, 255));
                rp[c] = 9'($urandom_range(0, 256));
            end
            for (int i = 0; i < SH; i++) ps[i] = 8'($urandom_range(0, 15) * 16);
            do_scan();
            for (int c = 0; c < NC; c++) begin
                model(c, eid, eirq);
                check_cpu("R1 R2 R3 R5 R6 random", c, eid, eirq);
            end
        end
    endtask

    initial begin
        clear_all();
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        t_empty();
        t_candidate();
        t_lowest();
        t_tie();
        t_mask();
        t_running();
        t_enables();
        t_bank();
        t_timing();
        t_random();
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule